// File: doc/BRIEF.md
# Dual Joystick Port TR/TH Controller

This block is the host side of a two-port joystick interface. Each port has up, down, left, right, a TL button, and two lines named TR and TH. TR and TH can be inputs or outputs. The host sees three registers behind one address bit and two strobes. Address 1 is a write-only control register: it sets the direction and the driven level of the four TR/TH lines. Address 0, on a write, loads a memory-control byte. The block drives the inverse of that byte on its own output bus, which the cartridge-select logic uses.

Reads return one of two 8-bit input ports, chosen by the address bit. A TR or TH line that is set as an output reads back the level the control register drives, not the pin. A control write that takes either TH output level from 0 to 1 fires a one-cycle strobe. An outside horizontal/vertical counter uses that strobe to capture its value.

A region input selects a restricted mode, and in that mode control writes are handled differently:
- Both TR lines are forced to inputs.
- Both TH levels are forced low.
- Two of the written bits are copied into the second input port.

A console-reset button is reported as a sticky low bit. It is held by a small two-state machine with these states and transitions:
- The states are BTN_IDLE (the bit reads 1) and BTN_HELD (the bit reads 0).
- PRESS goes from either state to BTN_HELD.
- SEED is a restricted-mode control write. It loads BTN_IDLE when written bit 0 is 1 and BTN_HELD when it is 0.
- ACK is a read of the second input port while in BTN_HELD, and it returns to BTN_IDLE.
- The priority is PRESS over SEED over ACK.

Top module: `jp_dual_port`

## Requirements
- R1: After reset, and before any write, the following values hold:
  - the control register is 0xFF, so pin_oe = 0000 and pin_lvl = 1111;
  - mem_sel_n is 0xFF, because the memory-control byte is 0;
  - the reset-button bit reads 1;
  - hv_latch is 0.
- R2: In normal mode (restricted = 0), a write with addr = 1 stores wdata into the control register. Its bit fields are:
  - bits 7, 6, 5, 4 are the output levels of B-TH, B-TR, A-TH and A-TR;
  - bits 3, 2, 1, 0 are the directions of the same four lines, in the same order, with 1 meaning input;
  - pin_lvl[3:0] = ctrl[7:4];
  - pin_oe[3:0] = ~ctrl[3:0], so pin_oe and pin_lvl bit order is {B-TH, B-TR, A-TH, A-TR}.
- R3: With addr = 0, rdata is the first input port, from bit 7 down: {B down, B up, A TR, A TL, A right, A left, A down, A up}.
  - The pad input encoding, used for pad_a and pad_b alike, is: bit 0 up, bit 1 down, bit 2 left, bit 3 right, bit 4 TL, bit 5 TR, bit 6 TH.
- R4: With addr = 1, rdata is the second input port, from bit 7 down: {B TH, A TH, CONT, RESET, B TR, B TL, B right, B left}.
- R5: When a TR or TH line is an output (its direction bit is 0), its read bit returns the stored level bit instead of the pad input:
  - A-TR reads ctrl[4];
  - B-TR reads ctrl[6];
  - A-TH reads ctrl[5];
  - B-TH reads ctrl[7].
- R6: hv_latch is high for exactly the one cycle after a normal-mode control write in which bit 7 or bit 5 goes from 0 in the old value to 1 in the new value. It is low otherwise.
- R7: In restricted mode, a control write stores (wdata | 0x05) & 0x5F. No such write raises hv_latch.
- R8: A restricted-mode control write copies wdata[2] into read bit 5 (CONT) and wdata[0] into read bit 4 (RESET) of the second input port.
- R9: A btn_press pulse makes read bit 4 of the second input port read 0 from the next cycle.
  - It stays 0 until a read with rd_en = 1 and addr = 1.
  - It reads 1 from the cycle after that read.
  - A press in the same cycle as the read wins.
- R10: A write with addr = 0 loads the memory-control byte, and mem_sel_n equals its bitwise inverse from the next cycle. Such a write leaves the control register unchanged.
- R11: After reset, the CONT read bit is 1 when compat = 0 and 0 when compat = 1. A normal-mode write does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restricted | input | 1 | Region select: 1 = restricted control handling |
| compat | input | 1 | Compatibility mode: 1 makes the CONT bit reset to 0 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe (a read at addr 1 acknowledges the reset button) |
| addr | input | 1 | 0 = memory control / first port, 1 = I/O control / second port |
| wdata | input | 8 | Write data |
| pad_a | input | 7 | Port A pin inputs {TH, TR, TL, right, left, down, up} |
| pad_b | input | 7 | Port B pin inputs, same layout |
| btn_press | input | 1 | Console reset button pressed (pulse) |
| rdata | output | 8 | Addressed input port, combinational |
| pin_oe | output | 4 | Output enables {B-TH, B-TR, A-TH, A-TR} |
| pin_lvl | output | 4 | Driven levels {B-TH, B-TR, A-TH, A-TR} |
| hv_latch | output | 1 | One-cycle counter-latch strobe |
| mem_sel_n | output | 8 | Inverted memory-control byte |

## Verification
The assertions assume the following about the inputs:
- restricted and compat stay constant outside reset;
- wr_en and rd_en are low during reset, so $past values seen just after reset are idle.

The bench changes restricted and compat only while rst_n is low. It keeps all strobes low throughout each reset. The bench compares every output on every cycle against a behavioural model. Its stimulus includes write patterns that raise TH from 0 to 1 and patterns that do not, press/read collisions, and random pad values under every direction setting.

// File: rtl/jp_pkg.sv
package jp_pkg;
    localparam int DATA_W  = 8;
    localparam int PAD_W   = 7;
    localparam int LINES   = 4;

    // pad bit positions
    localparam int P_UP    = 0;
    localparam int P_DOWN  = 1;
    localparam int P_LEFT  = 2;
    localparam int P_RIGHT = 3;
    localparam int P_TL    = 4;
    localparam int P_TR    = 5;
    localparam int P_TH    = 6;

    // control register: level bits 7..4, direction bits 3..0
    localparam int C_ATR   = 0;
    localparam int C_ATH   = 1;
    localparam int C_BTR   = 2;
    localparam int C_BTH   = 3;
    localparam int LVL_OFS = 4;

    localparam logic [DATA_W-1:0] CTRL_RST  = 8'hFF;
    localparam logic [DATA_W-1:0] RSTR_OR   = 8'h05;
    localparam logic [DATA_W-1:0] RSTR_AND  = 8'h5F;

    typedef enum logic {
        BTN_IDLE = 1'b0,
        BTN_HELD = 1'b1
    } btn_state_t;
endpackage

// File: rtl/jp_ctrl_regs.sv
module jp_ctrl_regs
    import jp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restricted,
    input  logic              compat,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] mem_q,
    output logic              cont_q,
    output logic              hv_q
);
    logic              ctrl_wr;
    logic              mem_wr;
    logic [DATA_W-1:0] ctrl_d;
    logic              th_rise;

    assign ctrl_wr = wr_en && addr;
    assign mem_wr  = wr_en && !addr;

    always_comb begin
        if (restricted) begin
            ctrl_d = (wdata | RSTR_OR) & RSTR_AND;
        end else begin
            ctrl_d = wdata;
        end
    end

    assign th_rise = (!ctrl_q[C_BTH+LVL_OFS] && wdata[C_BTH+LVL_OFS])
                  || (!ctrl_q[C_ATH+LVL_OFS] && wdata[C_ATH+LVL_OFS]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            mem_q  <= '0;
            cont_q <= !compat;
            hv_q   <= 1'b0;
        end else begin
            hv_q <= ctrl_wr && !restricted && th_rise;
            if (ctrl_wr) begin
                ctrl_q <= ctrl_d;
                if (restricted) begin
                    cont_q <= wdata[2];
                end
            end
            if (mem_wr) begin
                mem_q <= wdata;
            end
        end
    end
endmodule

// File: rtl/jp_btn_fsm.sv
module jp_btn_fsm
    import jp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic press,
    input  logic seed,
    input  logic seed_val,
    input  logic ack,
    output logic btn_bit
);
    btn_state_t state_q;
    btn_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (press) begin
            state_d = BTN_HELD;                          // PRESS
        end else if (seed) begin
            state_d = seed_val ? BTN_IDLE : BTN_HELD;    // SEED
        end else begin
            unique case (state_q)
                BTN_IDLE: state_d = BTN_IDLE;
                BTN_HELD: state_d = ack ? BTN_IDLE : BTN_HELD;   // ACK
                default:  state_d = BTN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BTN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            BTN_IDLE: btn_bit = 1'b1;
            BTN_HELD: btn_bit = 1'b0;
            default:  btn_bit = 1'b1;
        endcase
    end
endmodule

// File: rtl/jp_read_mux.sv
module jp_read_mux
    import jp_pkg::*;
(
    input  logic              addr,
    input  logic [DATA_W-1:0] ctrl,
    input  logic [PAD_W-1:0]  pad_a,
    input  logic [PAD_W-1:0]  pad_b,
    input  logic              cont,
    input  logic              btn_bit,
    output logic [DATA_W-1:0] rdata
);
    logic [LINES-1:0] pin_in;
    logic [LINES-1:0] pin_rd;

    assign pin_in[C_ATR] = pad_a[P_TR];
    assign pin_in[C_ATH] = pad_a[P_TH];
    assign pin_in[C_BTR] = pad_b[P_TR];
    assign pin_in[C_BTH] = pad_b[P_TH];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign pin_rd[i] = ctrl[i] ? pin_in[i] : ctrl[i+LVL_OFS];
    end

    always_comb begin
        if (!addr) begin
            rdata = {pad_b[P_DOWN], pad_b[P_UP], pin_rd[C_ATR], pad_a[P_TL],
                     pad_a[P_RIGHT], pad_a[P_LEFT], pad_a[P_DOWN], pad_a[P_UP]};
        end else begin
            rdata = {pin_rd[C_BTH], pin_rd[C_ATH], cont, btn_bit,
                     pin_rd[C_BTR], pad_b[P_TL], pad_b[P_RIGHT], pad_b[P_LEFT]};
        end
    end
endmodule

// File: rtl/jp_dual_port.sv
module jp_dual_port
    import jp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restricted,
    input  logic              compat,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PAD_W-1:0]  pad_a,
    input  logic [PAD_W-1:0]  pad_b,
    input  logic              btn_press,
    output logic [DATA_W-1:0] rdata,
    output logic [LINES-1:0]  pin_oe,
    output logic [LINES-1:0]  pin_lvl,
    output logic              hv_latch,
    output logic [DATA_W-1:0] mem_sel_n
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] mem_q;
    logic              cont_q;
    logic              btn_bit;

    jp_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .restricted (restricted),
        .compat     (compat),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .ctrl_q     (ctrl_q),
        .mem_q      (mem_q),
        .cont_q     (cont_q),
        .hv_q       (hv_latch)
    );

    jp_btn_fsm u_btn (
        .clk      (clk),
        .rst_n    (rst_n),
        .press    (btn_press),
        .seed     (wr_en && addr && restricted),
        .seed_val (wdata[0]),
        .ack      (rd_en && addr),
        .btn_bit  (btn_bit)
    );

    jp_read_mux u_mux (
        .addr    (addr),
        .ctrl    (ctrl_q),
        .pad_a   (pad_a),
        .pad_b   (pad_b),
        .cont    (cont_q),
        .btn_bit (btn_bit),
        .rdata   (rdata)
    );

    assign pin_lvl   = ctrl_q[DATA_W-1:LVL_OFS];
    assign pin_oe    = ~ctrl_q[LINES-1:0];
    assign mem_sel_n = ~mem_q;
endmodule

// File: rtl/jp_dual_port_chk.sv
module jp_dual_port_chk
    import jp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              restricted,
    input logic              wr_en,
    input logic              rd_en,
    input logic              addr,
    input logic [DATA_W-1:0] wdata,
    input logic              btn_press,
    input logic [DATA_W-1:0] rdata,
    input logic [LINES-1:0]  pin_oe,
    input logic [LINES-1:0]  pin_lvl,
    input logic              hv_latch,
    input logic [DATA_W-1:0] mem_sel_n
);
    // R2
    normal_ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && !restricted) |=>
        (pin_lvl == $past(wdata[7:4]) && pin_oe == ~$past(wdata[3:0])));

    // R5
    bth_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr && pin_oe[C_BTH]) |-> (rdata[7] == pin_lvl[C_BTH]));

    // R6
    hv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hv_latch |-> $past(wr_en && addr && !restricted));

    // R7
    restricted_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && restricted) |=>
        (!pin_oe[C_ATR] && !pin_oe[C_BTR] && !pin_lvl[C_ATH] && !pin_lvl[C_BTH]));

    // R9
    btn_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(btn_press) && addr) |-> !rdata[4]);

    // R10
    mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=> (mem_sel_n == ~$past(wdata)));
endmodule

bind jp_dual_port jp_dual_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .restricted (restricted),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .btn_press  (btn_press),
    .rdata      (rdata),
    .pin_oe     (pin_oe),
    .pin_lvl    (pin_lvl),
    .hv_latch   (hv_latch),
    .mem_sel_n  (mem_sel_n)
);

// File: tb/tb_jp_dual_port.sv
module tb_jp_dual_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restricted = 1'b0;
    logic       compat = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [6:0] pad_a = '0;
    logic [6:0] pad_b = '0;
    logic       btn_press = 1'b0;
    logic [7:0] rdata;
    logic [3:0] pin_oe;
    logic [3:0] pin_lvl;
    logic       hv_latch;
    logic [7:0] mem_sel_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_ctrl, m_mem, m_cont, m_btn, m_hv;

    always #2.5 clk = ~clk;

    jp_dual_port dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_rd(input int a);
        int r;
        int trA = m_ctrl[0] ? pad_a[5] : m_ctrl[4];
        int thA = m_ctrl[1] ? pad_a[6] : m_ctrl[5];
        int trB = m_ctrl[2] ? pad_b[5] : m_ctrl[6];
        int thB = m_ctrl[3] ? pad_b[6] : m_ctrl[7];
        if (a == 0)
            r = pad_b[1]*128 + pad_b[0]*64 + trA*32 + pad_a[4]*16 + pad_a[3]*8
              + pad_a[2]*4 + pad_a[1]*2 + pad_a[0];
        else
            r = thB*128 + thA*64 + m_cont*32 + m_btn*16 + trB*8
              + pad_b[4]*4 + pad_b[3]*2 + pad_b[2];
        return r;
    endfunction

    task automatic compare_all();
        int e;
        e = exp_rd(addr);
        chk(rdata == e[7:0], addr ? "R4/R5/R8/R9 port2" : "R3/R5 port1", rdata, e);
        chk(pin_lvl == m_ctrl[7:4], "R2/R7 pin_lvl", pin_lvl, m_ctrl[7:4]);
        chk(pin_oe == ~m_ctrl[3:0], "R2/R7 pin_oe", pin_oe, ~m_ctrl[3:0]);
        chk(hv_latch == m_hv[0], "R6 hv_latch", hv_latch, m_hv);
        chk(mem_sel_n == ~m_mem[7:0], "R10 mem_sel_n", mem_sel_n, ~m_mem[7:0]);
    endtask

    task automatic cyc(input bit we, input bit rd, input bit a, input int wd, input bit pr);
        int old;
        @(negedge clk);
        wr_en = we; rd_en = rd; addr = a; wdata = wd[7:0]; btn_press = pr;
        #1;
        compare_all();
        @(posedge clk);
        old = m_ctrl;
        m_hv = 0;
        if (we && a) begin
            if (restricted) begin
                m_ctrl = (wd | 5) & 'h5F;
                m_cont = wd[2];
            end else begin
                m_ctrl = wd & 'hFF;
                if ((!old[7] && wd[7]) || (!old[5] && wd[5])) m_hv = 1;
            end
        end
        if (we && !a) m_mem = wd & 'hFF;
        if (pr) m_btn = 0;
        else if (we && a && restricted) m_btn = wd[0];
        else if (rd && a) m_btn = 1;
    endtask

    task automatic do_reset(input bit r, input bit c);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; rd_en = 0; btn_press = 0;
        restricted = r; compat = c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_ctrl = 'hFF; m_mem = 0; m_cont = c ? 0 : 1; m_btn = 1; m_hv = 0;
        #1;
        // R1 reset state
        chk(pin_oe == 4'h0, "R1 pin_oe", pin_oe, 0);
        chk(pin_lvl == 4'hF, "R1 pin_lvl", pin_lvl, 'hF);
        chk(mem_sel_n == 8'hFF, "R1 mem_sel_n", mem_sel_n, 'hFF);
        chk(hv_latch == 1'b0, "R1 hv_latch", hv_latch, 0);
        addr = 1'b1; #0.5;
        // R11 CONT default
        chk(rdata[5] == !c, "R11 cont", rdata[5], !c);
        chk(rdata[4] == 1'b1, "R1 btn bit", rdata[4], 1);
    endtask

    task automatic rand_pads();
        pad_a = $urandom; pad_b = $urandom;
    endtask

    initial begin
        do_reset(0, 0);
        // R2/R6: TH rises on B and A, then no rise, then rises again
        cyc(1, 0, 1, 'h00, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(1, 0, 1, 'h80, 0);
        cyc(1, 0, 1, 'hA0, 0);
        cyc(1, 0, 1, 'hA0, 0);
        cyc(1, 0, 1, 'h00, 0);
        cyc(1, 0, 1, 'h20, 0);
        cyc(0, 0, 0, 0, 0);
        // R3/R4/R5 under every direction setting
        for (int d = 0; d < 16; d++) begin
            for (int l = 0; l < 16; l += 5) begin
                cyc(1, 0, 1, l * 16 + d, 0);
                for (int k = 0; k < 4; k++) begin
                    rand_pads();
                    cyc(0, k[0], k[1], 0, 0);
                end
            end
        end
        // R10 memory control; control register unchanged
        cyc(1, 0, 0, 'h5A, 0);
        cyc(1, 0, 0, 'hC3, 0);
        cyc(0, 0, 1, 0, 0);
        // R9 button latch
        cyc(0, 0, 1, 0, 1);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 1);
        cyc(0, 1, 1, 0, 1);
        cyc(0, 1, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        // R7/R8 restricted mode, R11 compat
        do_reset(1, 1);
        for (int v = 0; v < 8; v++) begin
            cyc(1, 0, 1, v * 37 + 1, 0);
            rand_pads();
            cyc(0, 0, 1, 0, 0);
            cyc(0, 0, 0, 0, 0);
        end
        cyc(1, 0, 1, 'hFF, 0);
        cyc(1, 0, 1, 'h00, 0);
        cyc(0, 0, 1, 0, 1);
        cyc(0, 1, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        // random mixed traffic in normal mode with compat
        do_reset(0, 1);
        for (int n = 0; n < 300; n++) begin
            rand_pads();
            cyc($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                $urandom_range(0, 255), $urandom_range(0, 9) == 0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule